// File: doc/BRIEF.md
# Serial Write-Only Register Port

This block terminates a three-wire serial link that carries write commands from a host controller into a bank of 33 eight-bit control registers. Each command is one 16-bit frame. The frame holds an 8-bit register address and then an 8-bit value, and both fields are sent most significant bit first. The serial clock, data and active-low select lines are brought into the system clock domain through two-flop synchronizers. Data is taken on each synchronized rising edge of the serial clock. The system clock must run at least eight times faster than the serial clock.

The register contents go to the LED engines as a flat vector. A ten-bit output-enable vector is decoded from two of the registers. The per-channel timing registers at 0Ah to 1Bh are staged. The engines see an active copy of these registers, and that copy changes only when a commit strobe fires. Any write to address 1Ch fires the strobe, whatever the data. No read-back path exists.

Top module: `spi_wr_regport`

## Requirements
- R1: A frame is 16 bits sent most significant bit first, address byte then data byte, each bit taken on a rising edge of `sck_i` while `csn_i` is low. At the end of the frame the addressed register (byte `k` of `regs_o` at bits `8k+7:8k`) holds the data byte.
- R2: After reset, register 00h reads 01h, 1Dh reads FFh, 1Eh reads C0h and every other register reads 00h. `timing_o` is all zero, `out_en_o` is 3FFh and `commit_o` is 0.
- R3: A frame in which `csn_i` rises before the 16th bit arrives changes no register and fires no commit.
- R4: The bit count restarts on every falling edge of `csn_i`, so a full frame sent after an aborted one is written correctly.
- R5: A frame whose address is above 20h changes no register.
- R6: A write of any data to 1Ch pulses `commit_o` high for exactly one system clock cycle. Register 1Ch always reads 00h.
- R7: A write to 0Ah..1Bh shows at once in `regs_o`. Byte `j` of `timing_o` (the active copy of register 0Ah+j) takes the staged value only after a commit, and it is otherwise held.
- R8: `out_en_o[7:0]` equals register 1Dh, with bit n enabling output n. `out_en_o[9]` is bit 7 of 1Eh and `out_en_o[8]` is bit 6 of 1Eh. Bits 5..0 of 1Eh are not stored and read 0.
- R9: Serial clock edges after the 16th in one frame are ignored, so a frame makes at most one write.
- R10: Serial clock edges while `csn_i` is high shift nothing and do not disturb the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock, asynchronous to `clk` |
| sdi_i | input | 1 | Serial data |
| csn_i | input | 1 | Active-low frame select |
| regs_o | output | 264 | All 33 registers, byte k at bits 8k+7:8k |
| timing_o | output | 144 | Active copies of registers 0Ah..1Bh, byte j for 0Ah+j |
| commit_o | output | 1 | One-cycle strobe after a write to 1Ch |
| out_en_o | output | 10 | Per-output enable vector |

## Verification
Two situations are hard to reach from the ports. The first is a frame that is cut short or carries surplus bits. The bench drives these with a bit-level task that sends any number of bits under one select, then follows each damaged frame with a clean one. A counter that is not cleared, or that is not capped, would then corrupt the clean write. The second is the gap between staging and committing timing values. The bench stages several timing registers and confirms that the active copy is unchanged. It then counts the system cycles in which `commit_o` is high across a write to 1Ch.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 8;
  localparam int NREG     = 33;
  localparam int TMG_LO   = 'h0A;
  localparam int TMG_HI   = 'h1B;
  localparam int NTMG     = TMG_HI - TMG_LO + 1;
  localparam int A_COMMIT = 'h1C;
  localparam int A_EN_LO  = 'h1D;
  localparam int A_EN_HI  = 'h1E;

  function automatic logic [DATA_W-1:0] srp_rst_val(int a);
    case (a)
      0:       return 8'h01;
      A_EN_LO: return 8'hFF;
      A_EN_HI: return 8'hC0;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] srp_wmask(int a);
    case (a)
      A_COMMIT: return 8'h00;
      A_EN_HI:  return 8'hC0;
      default:  return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] nxt;
      if (s == 0) begin : g_first
        always_comb nxt = d;
      end else begin : g_rest
        always_comb nxt = st[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[s] <= RST_VAL;
        else        st[s] <= nxt;
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/srp_deframe.sv
module srp_deframe
  import srp_pkg::*;
#(
  parameter int FRAME_W = ADDR_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              sdi_s,
  input  logic              csn_s,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

  logic               sck_q, csn_q;
  logic [FRAME_W-1:0] shift_q, shift_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               stb_q, stb_d;
  logic               sck_rise, cs_fall;

  assign sck_rise = sck_s & ~sck_q;
  assign cs_fall  = ~csn_s & csn_q;

  always_comb begin
    shift_d = shift_q;
    cnt_d   = cnt_q;
    stb_d   = 1'b0;
    if (cs_fall || csn_s) begin
      cnt_d = '0;
    end else if (sck_rise && (cnt_q < FULL)) begin
      shift_d = {shift_q[FRAME_W-2:0], sdi_s};
      cnt_d   = cnt_q + 1'b1;
      stb_d   = (cnt_q == LAST);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      csn_q   <= 1'b1;
      shift_q <= '0;
      cnt_q   <= '0;
      stb_q   <= 1'b0;
    end else begin
      sck_q   <= sck_s;
      csn_q   <= csn_s;
      shift_q <= shift_d;
      cnt_q   <= cnt_d;
      stb_q   <= stb_d;
    end
  end

  assign wr_stb  = stb_q;
  assign wr_addr = shift_q[FRAME_W-1 -: ADDR_W];
  assign wr_data = shift_q[DATA_W-1:0];

  // R9: the bit count never passes the frame length
  a_r9_cnt_capped: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);
  // R1: a write is issued only once a full frame has been counted
  a_r1_stb_full_frame: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (cnt_q == FULL));
  // R4: a select falling edge restarts the count
  a_r4_cs_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (cnt_q == '0));
  // R10: with select high the count stays at zero
  a_r10_idle_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> (cnt_q == '0));
endmodule

// File: rtl/srp_regfile.sv
module srp_regfile
  import srp_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_stb,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  output logic [NREG*DATA_W-1:0]   regs_o,
  output logic [NTMG*DATA_W-1:0]   timing_o,
  output logic                     commit_o
);
  logic commit_q, commit_d;

  always_comb commit_d = wr_stb && (wr_addr == ADDR_W'(A_COMMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) commit_q <= 1'b0;
    else        commit_q <= commit_d;
  end

  genvar k;
  generate
    for (k = 0; k < NREG; k++) begin : g_reg
      localparam logic [DATA_W-1:0] RV = srp_rst_val(k);
      localparam logic [DATA_W-1:0] WM = srp_wmask(k);
      logic [DATA_W-1:0] q, d;
      logic              en;
      always_comb begin
        en = wr_stb && (wr_addr == ADDR_W'(k));
        d  = wr_data & WM;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= RV;
        else if (en) q <= d;
      end
      assign regs_o[k*DATA_W +: DATA_W] = q;
    end

    for (k = 0; k < NTMG; k++) begin : g_act
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q <= '0;
        else if (commit_q) q <= regs_o[(TMG_LO + k)*DATA_W +: DATA_W];
      end
      assign timing_o[k*DATA_W +: DATA_W] = q;
    end
  endgenerate

  assign commit_o = commit_q;

  // R6: the commit strobe lasts a single cycle
  a_r6_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !commit_o);
  // R6: the commit strobe follows a write to the commit address
  a_r6_commit_cause: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> ($past(wr_stb) && ($past(wr_addr) == ADDR_W'(A_COMMIT))));
  // R7: the active timing copy holds unless a commit fires
  a_r7_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_o |=> $stable(timing_o));
  // R5: out-of-range addresses leave every register untouched
  a_r5_high_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && (int'(wr_addr) >= NREG)) |=> $stable(regs_o));
endmodule

// File: rtl/spi_wr_regport.sv
module spi_wr_regport
  import srp_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sck_i,
  input  logic                   sdi_i,
  input  logic                   csn_i,
  output logic [NREG*DATA_W-1:0] regs_o,
  output logic [NTMG*DATA_W-1:0] timing_o,
  output logic                   commit_o,
  output logic [9:0]             out_en_o
);
  logic              sck_s, sdi_s, csn_s;
  logic              wr_stb;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  srp_sync #(.W(3), .STAGES(2), .RST_VAL(3'b001)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sck_i, sdi_i, csn_i}),
    .q     ({sck_s, sdi_s, csn_s})
  );

  srp_deframe u_deframe (
    .clk     (clk),
    .rst_n   (rst_n),
    .sck_s   (sck_s),
    .sdi_s   (sdi_s),
    .csn_s   (csn_s),
    .wr_stb  (wr_stb),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  srp_regfile u_regfile (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stb   (wr_stb),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .regs_o   (regs_o),
    .timing_o (timing_o),
    .commit_o (commit_o)
  );

  assign out_en_o = {regs_o[A_EN_HI*DATA_W + 7 -: 2], regs_o[A_EN_LO*DATA_W +: DATA_W]};
endmodule

// File: tb/tb_spi_wr_regport.sv
module tb_spi_wr_regport;
  localparam int NR = 33;
  localparam int NT = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, sdi = 1'b0, csn = 1'b1;
  logic [NR*8-1:0] regs;
  logic [NT*8-1:0] tmg;
  logic            commit;
  logic [9:0]      oen;

  int checks = 0;
  int errors = 0;
  int commit_hi = 0;
  logic [7:0] exp_r [NR];
  logic [7:0] exp_t [NT];

  always #2 clk = ~clk;

  spi_wr_regport dut (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .sdi_i(sdi), .csn_i(csn),
    .regs_o(regs), .timing_o(tmg), .commit_o(commit), .out_en_o(oen)
  );

  always @(negedge clk) if (rst_n && commit) commit_hi++;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    for (int k = 0; k < NR; k++)
      check(req, $sformatf("reg %02h", k), {24'b0, regs[8*k +: 8]}, {24'b0, exp_r[k]});
    for (int j = 0; j < NT; j++)
      check(req, $sformatf("active %02h", j + 10), {24'b0, tmg[8*j +: 8]}, {24'b0, exp_t[j]});
    check(req, "out_en", {22'b0, oen}, {22'b0, exp_r[30][7:6], exp_r[29]});
  endtask

  // model of a completed write, built from the requirements
  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    if (a < NR) begin
      if (a == 8'h1C) begin
        for (int j = 0; j < NT; j++) exp_t[j] = exp_r[10 + j];
      end else if (a == 8'h1E) exp_r[a] = d & 8'hC0;
      else exp_r[a] = d;
    end
  endtask

  // send the low n bits of v, highest first, under one select
  task automatic xfer(input int n, input logic [31:0] v);
    csn = 1'b0;
    wait_clk(8);
    for (int b = n - 1; b >= 0; b--) begin
      sdi = v[b];
      wait_clk(8);
      sck = 1'b1;
      wait_clk(8);
      sck = 1'b0;
    end
    wait_clk(4);
    csn = 1'b1;
    wait_clk(12);
  endtask

  task automatic write(input logic [7:0] a, input logic [7:0] d);
    xfer(16, {16'b0, a, d});
    model_write(a, d);
  endtask

  task automatic t_reset;
    for (int k = 0; k < NR; k++) exp_r[k] = 8'h00;
    exp_r[0] = 8'h01; exp_r[29] = 8'hFF; exp_r[30] = 8'hC0;
    for (int j = 0; j < NT; j++) exp_t[j] = 8'h00;
    check_state("R2");
    check("R2", "out_en", {22'b0, oen}, 32'h3FF);
    check("R2", "commit", {31'b0, commit}, 32'h0);
  endtask

  task automatic t_basic;
    write(8'h04, 8'hA5);
    write(8'h20, 8'h5A);
    write(8'h00, 8'h3C);
    write(8'h1F, 8'h81);
    check_state("R1");
  endtask

  task automatic t_outen;
    write(8'h1D, 8'h7F);
    write(8'h1E, 8'hBF);
    check("R8", "out_en", {22'b0, oen}, 32'h27F);
    check("R8", "reg 1E", {24'b0, regs[8*30 +: 8]}, 32'h80);
    check_state("R8");
  endtask

  task automatic t_abort;
    xfer(10, {22'b0, 8'h05, 2'b11});
    check_state("R3");
    write(8'h05, 8'h11);
    check("R4", "reg 05 after abort", {24'b0, regs[8*5 +: 8]}, 32'h11);
    check_state("R4");
  endtask

  task automatic t_high_addr;
    write(8'h21, 8'hFF);
    write(8'hFF, 8'hEE);
    check_state("R5");
  endtask

  task automatic t_timing;
    int c0;
    write(8'h0A, 8'h33);
    write(8'h1B, 8'h77);
    check("R7", "staged 0A", {24'b0, regs[8*10 +: 8]}, 32'h33);
    check("R7", "active 0A before commit", {24'b0, tmg[7:0]}, 32'h00);
    check("R7", "active 1B before commit", {24'b0, tmg[8*17 +: 8]}, 32'h00);
    c0 = commit_hi;
    write(8'h1C, 8'h9E);
    check("R6", "commit cycles", commit_hi - c0, 32'd1);
    check("R6", "reg 1C", {24'b0, regs[8*28 +: 8]}, 32'h00);
    check("R7", "active 0A after commit", {24'b0, tmg[7:0]}, 32'h33);
    check_state("R7");
    c0 = commit_hi;
    write(8'h0B, 8'h44);
    check("R6", "no commit on other write", commit_hi - c0, 32'd0);
  endtask

  task automatic t_long;
    xfer(20, {12'b0, 8'h06, 8'h44, 4'hF});
    model_write(8'h06, 8'h44);
    check("R9", "reg 06", {24'b0, regs[8*6 +: 8]}, 32'h44);
    check_state("R9");
  endtask

  task automatic t_idle_sck;
    sdi = 1'b1;
    for (int i = 0; i < 5; i++) begin
      wait_clk(8); sck = 1'b1; wait_clk(8); sck = 1'b0;
    end
    wait_clk(8);
    check_state("R10");
    write(8'h07, 8'h12);
    check("R10", "reg 07", {24'b0, regs[8*7 +: 8]}, 32'h12);
    check_state("R10");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset;
    t_basic;
    t_outen;
    t_abort;
    t_high_addr;
    t_timing;
    t_long;
    t_idle_sck;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule